// File: doc/BRIEF.md
# Sixteen-Channel Grayscale PWM Engine

This block turns sixteen 12-bit intensity values into sixteen on/off channel outputs. It runs on a grayscale clock. A blanking input frames each PWM period. While blanking is high, every channel is dark and the period counter sits at zero. On each grayscale clock after blanking falls, a 12-bit counter steps through 4096 counts. A channel is lit while the count is below its intensity value, so each channel's lit time, counted in grayscale clocks, equals its value.

The intensity values arrive as one flat 192-bit word from the latch stage of a serial loader, and they act on the outputs at once. A mid-period load therefore changes the waveform immediately. To avoid this, the controller can watch the end-of-period flag, which is high for one clock on the last count of each period. After that count the engine stays dark and idle until the next blanking pulse.

Top module: `gs_pwm_engine`

## Requirements
- R1: After reset, with blanking low, all channel outputs and the end flag are low, and they stay low until a blanking pulse has been seen.
- R2: While blanking is high, all channel outputs and the end flag are low, whatever the intensity values are.
- R3: A period starts on the first grayscale clock with blanking low after a blanking pulse. It covers 4096 clocks with counts 0 to 4095. A channel is high during exactly the clocks whose count is below its value, so its high time is one unbroken run at the start of the period.
- R4: Channel i takes its intensity from bits [12*i+11 : 12*i] of the intensity word. Channel 0 uses the least significant field.
- R5: A channel with value 0 is never high. A channel with value 4095 is high for 4095 of the 4096 clocks.
- R6: The end flag is high for exactly one clock per period, on the clock with count 4095, which is the 4096th clock of the period.
- R7: After the end flag, all outputs stay low and the end flag does not rise again until blanking has been pulsed once more.
- R8: A change to the intensity word during a period acts from the clock in which it is applied. Counts already passed keep the old value, and the remaining counts use the new one.
- R9: A blanking pulse in the middle of a period cuts that period short. Once blanking falls, a new, complete 4096-clock period follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gs_clk | input | 1 | Grayscale clock; every state change happens on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| blank_i | input | 1 | Blanking: forces the outputs dark and re-arms the counter at zero |
| level_i | input | 192 | Sixteen 12-bit intensity fields, channel 0 in the low bits |
| chan_on_o | output | 16 | Channel on/off outputs |
| period_end_o | output | 1 | High during the last count of a running period |

## Verification
The assertions assume that blanking and the intensity word change only between grayscale clock edges and are steady at each rising edge. They also assume that a period is started only by a blanking pulse that lasts at least one edge. The bench drives every input half a period away from the rising edge. Each blanking pulse it applies is at least two clocks long. It draws intensity values from a fixed-seed random stream, mixed with the extreme values 0, 1, 4094 and 4095. It counts each channel's lit clocks over whole periods, across mid-period loads and across aborted periods.

// File: rtl/gs_pwm_pkg.sv
// Package: gs_pwm_pkg
// Shared defaults and helpers for the grayscale PWM engine.
// Assumes: intensity fields are packed contiguously, channel 0 lowest.
package gs_pwm_pkg;

    localparam int unsigned GS_CHANNELS_DEF = 16;
    localparam int unsigned GS_BITS_DEF     = 12;

    // Returns the low bit position of channel ch's intensity field.
    function automatic int unsigned field_lsb(input int unsigned ch, input int unsigned bits);
        return ch * bits;
    endfunction

endpackage

// File: rtl/gs_period_counter.sv
// Module: gs_period_counter
// Counts grayscale clocks across one PWM period and tracks whether a
// period is running. Blanking clears the count and arms a period. The
// count then climbs to its maximum, stays there and drops the run flag.
// Assumes: blank_i is synchronous to gs_clk.
module gs_period_counter #(
    parameter int unsigned CNT_BITS = 12
) (
    input  logic                gs_clk,
    input  logic                rst_n,
    input  logic                blank_i,
    output logic [CNT_BITS-1:0] count_o,
    output logic                run_o,
    output logic                last_o
);

    localparam logic [CNT_BITS-1:0] CNT_MAX = {CNT_BITS{1'b1}};

    logic [CNT_BITS-1:0] count_q;
    logic                run_q;

    // Period count and run flag: clear and arm on blank, step while running.
    always_ff @(posedge gs_clk) begin
        if (!rst_n) begin
            count_q <= '0;
            run_q   <= 1'b0;
        end else if (blank_i) begin
            count_q <= '0;
            run_q   <= 1'b1;
        end else if (run_q) begin
            if (count_q == CNT_MAX) begin
                run_q <= 1'b0;
            end else begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    // Last-count flag, shown only while a period is live.
    always_comb begin
        last_o = run_q && !blank_i && (count_q == CNT_MAX);
    end

    assign count_o = count_q;
    assign run_o   = run_q;

    AST_BLANK_REARM: assert property (@(posedge gs_clk) disable iff (!rst_n)
        blank_i |=> (count_o == '0) && run_o);                          // R2
    AST_COUNT_STEP: assert property (@(posedge gs_clk) disable iff (!rst_n)
        (!blank_i && run_o && count_o != CNT_MAX) |=> (count_o == $past(count_o) + 1'b1)); // R3
    AST_IDLE_HOLD: assert property (@(posedge gs_clk) disable iff (!rst_n)
        (!blank_i && !run_o) |=> (!run_o && $stable(count_o)));         // R7

endmodule

// File: rtl/gs_chan_compare.sv
// Module: gs_chan_compare
// One channel's PWM decision: the channel is lit while a period runs,
// blanking is low and the period count is below the channel's value.
// Assumes: level_i is steady at each rising edge of the grayscale clock.
module gs_chan_compare #(
    parameter int unsigned CNT_BITS = 12
) (
    input  logic                gs_clk,
    input  logic                rst_n,
    input  logic [CNT_BITS-1:0] level_i,
    input  logic [CNT_BITS-1:0] count_i,
    input  logic                run_i,
    input  logic                blank_i,
    output logic                on_o
);

    // Channel on/off compare.
    always_comb begin
        on_o = run_i && !blank_i && (count_i < level_i);
    end

    AST_ZERO_DARK: assert property (@(posedge gs_clk) disable iff (!rst_n)
        (level_i == '0) |-> !on_o);                                     // R5

endmodule

// File: rtl/gs_pwm_engine.sv
// Module: gs_pwm_engine
// Sixteen-channel grayscale PWM engine. A shared period counter feeds one
// comparator per channel. The channel fields are cut from a flat word.
// Assumes: level_i comes from an external latch and acts immediately;
// the controller aligns its loads with period_end_o.
module gs_pwm_engine
    import gs_pwm_pkg::*;
#(
    parameter int unsigned CHANNELS = GS_CHANNELS_DEF,
    parameter int unsigned GS_BITS  = GS_BITS_DEF
) (
    input  logic                        gs_clk,
    input  logic                        rst_n,
    input  logic                        blank_i,
    input  logic [CHANNELS*GS_BITS-1:0] level_i,
    output logic [CHANNELS-1:0]         chan_on_o,
    output logic                        period_end_o
);

    logic [GS_BITS-1:0] count_w;
    logic               run_w;
    logic               last_w;

    gs_period_counter #(
        .CNT_BITS (GS_BITS)
    ) u_counter (
        .gs_clk  (gs_clk),
        .rst_n   (rst_n),
        .blank_i (blank_i),
        .count_o (count_w),
        .run_o   (run_w),
        .last_o  (last_w)
    );

    // One comparator per channel, each on its own intensity field.
    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        localparam int unsigned LSB = field_lsb(ch, GS_BITS);
        gs_chan_compare #(
            .CNT_BITS (GS_BITS)
        ) u_cmp (
            .gs_clk  (gs_clk),
            .rst_n   (rst_n),
            .level_i (level_i[LSB +: GS_BITS]),
            .count_i (count_w),
            .run_i   (run_w),
            .blank_i (blank_i),
            .on_o    (chan_on_o[ch])
        );
    end

    assign period_end_o = last_w;

    AST_BLANK_DARK: assert property (@(posedge gs_clk) disable iff (!rst_n)
        blank_i |-> (chan_on_o == '0) && !period_end_o);                // R2
    AST_END_SINGLE: assert property (@(posedge gs_clk) disable iff (!rst_n)
        period_end_o |=> !period_end_o);                                // R6
    AST_END_THEN_DARK: assert property (@(posedge gs_clk) disable iff (!rst_n)
        (period_end_o && !blank_i) |=> (chan_on_o == '0));              // R7

endmodule

// File: tb/test_gs_pwm_engine.sv
module test_gs_pwm_engine;

    localparam int CH   = 16;
    localparam int BITS = 12;
    localparam int PER  = 4096;

    logic             gs_clk = 1'b0;
    logic             rst_n  = 1'b0;
    logic             blank_i = 1'b0;
    logic [CH*BITS-1:0] level_i = '0;
    logic [CH-1:0]    chan_on_o;
    logic             period_end_o;

    int checks = 0;
    int fails  = 0;

    int lit   [CH];
    int ends;
    int first_end_step;

    always #4 gs_clk = ~gs_clk;

    gs_pwm_engine i_gs_pwm_engine (
        .gs_clk       (gs_clk),
        .rst_n        (rst_n),
        .blank_i      (blank_i),
        .level_i      (level_i),
        .chan_on_o    (chan_on_o),
        .period_end_o (period_end_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [CH*BITS-1:0] pack(input int v[CH]);
        logic [CH*BITS-1:0] w = '0;
        for (int c = 0; c < CH; c++) w[c*BITS +: BITS] = v[c][BITS-1:0];
        return w;
    endfunction

    // Expected lit clocks when the value moves from a to b at step k.
    function automatic int exp_lit(input int a, input int b, input int k);
        int lo = (k < a) ? k : a;
        int hi = (b > k) ? (b - k) : 0;
        return lo + hi;
    endfunction

    task automatic clear_counts();
        for (int c = 0; c < CH; c++) lit[c] = 0;
        ends = 0;
        first_end_step = -1;
    endtask

    // One step: wait for the falling edge, leave inputs as set, then sample.
    task automatic sample_step(input int step);
        #1;
        for (int c = 0; c < CH; c++) if (chan_on_o[c]) lit[c]++;
        if (period_end_o) begin
            ends++;
            if (first_end_step < 0) first_end_step = step;
        end
    endtask

    task automatic do_blank(input int n);
        @(negedge gs_clk);
        blank_i = 1'b1;
        for (int i = 0; i < n; i++) begin
            #1;
            check(chan_on_o == '0 && !period_end_o, "R2", int'(chan_on_o), 0);
            @(negedge gs_clk);
        end
        blank_i = 1'b0;
    endtask

    // Runs a period that has already been released; values may change at step k.
    task automatic run_period(input int va[CH], input int vb[CH], input int k, input string req);
        clear_counts();
        for (int s = 0; s < PER; s++) begin
            if (s > 0) @(negedge gs_clk);
            if (s == k) level_i = pack(vb);
            sample_step(s);
        end
        for (int c = 0; c < CH; c++)
            check(lit[c] == exp_lit(va[c], vb[c], k), req, lit[c], exp_lit(va[c], vb[c], k));
        check(ends == 1, "R6", ends, 1);
        check(first_end_step == PER-1, "R6", first_end_step, PER-1);
        // R7: stays dark and quiet after the period ends.
        clear_counts();
        for (int s = 0; s < 20; s++) begin
            @(negedge gs_clk);
            sample_step(s);
        end
        check(ends == 0, "R7", ends, 0);
        for (int c = 0; c < CH; c++) check(lit[c] == 0, "R7", lit[c], 0);
    endtask

    initial begin : watchdog
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int v[CH];
        int w[CH];
        void'($urandom(32'h5EED_0042));

        repeat (3) @(negedge gs_clk);
        rst_n = 1'b1;
        // R1: idle after reset, even with nonzero levels.
        for (int c = 0; c < CH; c++) v[c] = 4095;
        level_i = pack(v);
        clear_counts();
        for (int s = 0; s < 50; s++) begin
            @(negedge gs_clk);
            sample_step(s);
        end
        check(lit[0] == 0 && lit[15] == 0, "R1", lit[0], 0);
        check(ends == 0, "R1", ends, 0);

        // R5 and R4: directed extremes, distinct per channel.
        v[0] = 0; v[1] = 4095; v[2] = 1; v[3] = 4094;
        for (int c = 4; c < CH; c++) v[c] = c * 97;
        level_i = pack(v);
        do_blank(2);
        run_period(v, v, PER, "R5");

        // R3/R4: random levels over several periods.
        for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < CH; c++) v[c] = int'($urandom % 4096);
            level_i = pack(v);
            do_blank(2 + p);
            run_period(v, v, PER, "R3");
        end

        // R8: mid-period change at a random step.
        for (int c = 0; c < CH; c++) begin
            v[c] = int'($urandom % 4096);
            w[c] = int'($urandom % 4096);
        end
        level_i = pack(v);
        do_blank(2);
        run_period(v, w, 1000 + int'($urandom % 2000), "R8");

        // R9: abort a period midway, then verify a full new period.
        for (int c = 0; c < CH; c++) v[c] = int'($urandom % 4096);
        level_i = pack(v);
        do_blank(2);
        repeat (1500) @(negedge gs_clk);
        do_blank(3);
        run_period(v, v, PER, "R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule